// File: doc/BRIEF.md
# Polyphase FIR Convolution Address Sequencer

This block produces the addresses and controls for one output sample of a sample-rate converter's polyphase FIR filter. A strobe marks each output sample. With that strobe, a servo loop supplies a starting position in the input-sample buffer, which is the integer part, and a fractional phase into the coefficient table. The sequencer then issues one tap per clock. For each tap the buffer address steps back by one. The coefficient address steps forward by a ratio-derived increment, and the channel ends when that address overflows.

A single multiply-accumulate path serves both audio channels. The sequencer first runs the left channel to completion. It then reloads the same starting pointers and runs the right channel with no idle cycle between them. With each tap it drives a clear flag on the first tap of a channel and an enable flag on every tap. One cycle after the last tap of a channel it pulses a result strobe tagged with that channel.

The increment comes from the output/input rate ratio, an unsigned value with 20 fractional bits. A ratio at or above 1.0 gives 64 taps per channel. A smaller ratio lengthens the filter in proportion. The upper six bits of the coefficient address select the coefficient, and the lower twenty bits are the sub-phase.

Top module: `fir_seq`

## Requirements
- R1: When `start_i` is high at a clock edge while no convolution runs, the first tap appears in the next cycle with `ram_addr_o` equal to `ram_ptr_i` and `rom_addr_o` equal to `rom_phase_i` zero-extended to 26 bits.
- R2: On each subsequent tap of a channel, `ram_addr_o` is the previous tap's value minus one, modulo 128, so address 0 is followed by 127.
- R3: On each subsequent tap of a channel, `rom_addr_o` is the previous value plus a step. The step is the `ratio_i` value, clamped to at most 0x100000 (1.0) and at least 0x010000 (1/16).
- R4: A channel ends on the tap whose coefficient address plus the step reaches 2^26. This gives ceil((2^26 - phase) / step) taps, which is 64 when the ratio is at or above 1.0.
- R5: Left-channel taps (`ch_o` = 0) run first. The right-channel taps (`ch_o` = 1) follow in the very next cycle and restart from the same latched buffer pointer and phase.
- R6: `res_valid_o` is high for exactly one cycle, one cycle after a channel's last tap, with `res_ch_o` giving that channel (0 left, 1 right).
- R7: A `start_i` that arrives while taps are being issued raises `overrun_o` for one cycle in the next cycle. It is otherwise ignored, and the running sequence continues unchanged.
- R8: The pointer, phase and ratio inputs are captured when a start is accepted. Changing them during a convolution has no effect on its addresses.
- R9: While `rst_n` is low at a clock edge, the block returns to idle. In the cycle after that edge, `mac_en_o`, `mac_clr_o`, `res_valid_o`, `overrun_o`, `ch_o` and both addresses are zero.
- R10: `mac_en_o` is high on every tap and low otherwise. `mac_clr_o` is high only on the first tap of each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Output-sample strobe |
| ram_ptr_i | input | 7 | Starting buffer address (servo integer part) |
| rom_phase_i | input | 20 | Starting coefficient phase (servo fractional part) |
| ratio_i | input | 21 | Output/input rate ratio, 20 fractional bits |
| ram_addr_o | output | 7 | Sample buffer address of the current tap |
| rom_addr_o | output | 26 | Coefficient address of the current tap; bits 25:20 index the table |
| ch_o | output | 1 | Channel of the current tap (0 left, 1 right) |
| mac_clr_o | output | 1 | Clear accumulator: first tap of a channel |
| mac_en_o | output | 1 | Accumulate enable: a tap is issued |
| res_valid_o | output | 1 | Accumulated result of a channel is complete |
| res_ch_o | output | 1 | Channel whose result is complete |
| overrun_o | output | 1 | A start arrived during a busy convolution |

## Verification
Tap 0 of the left channel is due in the cycle after the edge that accepts the start. Tap k of that channel is due k cycles later. Right tap k is due N+k cycles after tap 0, where N is the per-channel tap count that the bench derives from phase and step. The result strobe is due one cycle after each channel's last tap, which for the left channel coincides with the first right tap. An overrun flag is due one cycle after the stray strobe. The bench samples on the falling edge in exactly those cycles, and it scrambles the inputs right after each start to show that only the captured values matter.

// File: rtl/fir_seq_pkg.sv
// Shared types for the convolution address sequencer.
package fir_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/fir_seq_step.sv
// Step register: clamps the rate ratio into [1/2^MIN_SHIFT, 1.0] and holds
// the result for the whole convolution. Assumes ratio has FRAC_W fractional bits.
module fir_seq_step #(
    parameter int FRAC_W    = 20,
    parameter int MIN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FRAC_W:0]   ratio_i,
    output logic [FRAC_W:0]   step_o
);
    localparam logic [FRAC_W:0] UNITY   = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [FRAC_W:0] MIN_INC = UNITY >> MIN_SHIFT;

    logic [FRAC_W:0] clamped;

    // Saturate the ratio at unity and floor it at the minimum increment.
    always_comb begin
        if (ratio_i >= UNITY)
            clamped = UNITY;
        else if (ratio_i < MIN_INC)
            clamped = MIN_INC;
        else
            clamped = ratio_i;
    end

    // Capture the clamped step when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_o <= UNITY;
        else if (load_i)
            step_o <= clamped;
    end
endmodule

// File: rtl/fir_seq_addr.sv
// Address pointers: holds the captured start pointers, steps the buffer address
// down by one and the coefficient address up by the step, and flags the tap
// whose coefficient increment overflows. Assumes the step is stable while advancing.
module fir_seq_addr #(
    parameter int RAM_AW = 7,
    parameter int ROM_IW = 6,
    parameter int FRAC_W = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      reload_i,
    input  logic                      adv_i,
    input  logic [RAM_AW-1:0]         ptr_i,
    input  logic [FRAC_W-1:0]         phase_i,
    input  logic [FRAC_W:0]           step_i,
    output logic [RAM_AW-1:0]         ram_o,
    output logic [ROM_IW+FRAC_W-1:0]  rom_o,
    output logic                      last_o
);
    localparam int ROM_W = ROM_IW + FRAC_W;

    logic [RAM_AW-1:0] base_ram;
    logic [FRAC_W-1:0] base_ph;
    logic [ROM_W:0]    rom_sum;

    // Coefficient address plus step, one bit wider to expose the rollover.
    always_comb begin
        rom_sum = {1'b0, rom_o} + {{ROM_IW{1'b0}}, step_i};
        last_o  = rom_sum[ROM_W];
    end

    // Latch the start pointers on acceptance, for the second channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_ram <= '0;
            base_ph  <= '0;
        end else if (load_i) begin
            base_ram <= ptr_i;
            base_ph  <= phase_i;
        end
    end

    // Load, reload or advance the running tap pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_o <= '0;
            rom_o <= '0;
        end else if (load_i) begin
            ram_o <= ptr_i;
            rom_o <= {{ROM_IW{1'b0}}, phase_i};
        end else if (reload_i) begin
            ram_o <= base_ram;
            rom_o <= {{ROM_IW{1'b0}}, base_ph};
        end else if (adv_i) begin
            ram_o <= ram_o - 1'b1;
            rom_o <= rom_sum[ROM_W-1:0];
        end
    end
endmodule

// File: rtl/fir_seq_ctrl.sv
// Sequencing state machine: idle, left channel, right channel. Accepts a start
// only when idle, flags stray starts, and emits MAC controls and result strobes.
// Assumes last_i marks the current tap as the final one of its channel.
module fir_seq_ctrl
    import fir_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic reload_o,
    output logic adv_o,
    output logic ch_o,
    output logic mac_clr_o,
    output logic mac_en_o,
    output logic res_valid_o,
    output logic res_ch_o,
    output logic overrun_o
);
    seq_state_t state;
    logic       first_q;

    // Decode pointer commands from the state and the wrap flag.
    always_comb begin
        load_o   = (state == ST_IDLE) && start_i;
        reload_o = (state == ST_LEFT) && last_i;
        adv_o    = (state != ST_IDLE) && !last_i;
        mac_en_o = (state != ST_IDLE);
        ch_o     = (state == ST_RIGHT);
        mac_clr_o = first_q;
    end

    // Advance the channel state and track the first tap of each channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state   <= ST_LEFT;
                        first_q <= 1'b1;
                    end
                end
                ST_LEFT: begin
                    if (last_i) begin
                        state   <= ST_RIGHT;
                        first_q <= 1'b1;
                    end else begin
                        first_q <= 1'b0;
                    end
                end
                ST_RIGHT: begin
                    first_q <= 1'b0;
                    if (last_i)
                        state <= ST_IDLE;
                end
                default: begin
                    state   <= ST_IDLE;
                    first_q <= 1'b0;
                end
            endcase
        end
    end

    // Pulse the result strobe after a channel's final tap and flag stray starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_ch_o    <= 1'b0;
            overrun_o   <= 1'b0;
        end else begin
            res_valid_o <= (state != ST_IDLE) && last_i;
            res_ch_o    <= (state == ST_RIGHT);
            overrun_o   <= (state != ST_IDLE) && start_i;
        end
    end

    // R10: the clear flag only appears on an issued tap.
    a_r10_clr_in_tap: assert property (@(posedge clk) disable iff (!rst_n)
        mac_clr_o |-> mac_en_o);

    // R7: an overrun flag follows a start seen during a busy cycle.
    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ($past(start_i) && $past(mac_en_o)));
endmodule

// File: rtl/fir_seq.sv
// Polyphase FIR convolution address sequencer top. For each output-sample strobe
// it issues a left then a right run of taps for a shared MAC. Each run ends when
// the ratio-stepped coefficient address rolls over. Assumes the strobe comes
// from the servo with its pointer and phase valid in the same cycle.
module fir_seq #(
    parameter int RAM_AW    = 7,
    parameter int ROM_IW    = 6,
    parameter int FRAC_W    = 20,
    parameter int MIN_SHIFT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [RAM_AW-1:0]         ram_ptr_i,
    input  logic [FRAC_W-1:0]         rom_phase_i,
    input  logic [FRAC_W:0]           ratio_i,
    output logic [RAM_AW-1:0]         ram_addr_o,
    output logic [ROM_IW+FRAC_W-1:0]  rom_addr_o,
    output logic                      ch_o,
    output logic                      mac_clr_o,
    output logic                      mac_en_o,
    output logic                      res_valid_o,
    output logic                      res_ch_o,
    output logic                      overrun_o
);
    localparam int ROM_W = ROM_IW + FRAC_W;

    logic            load_w, reload_w, adv_w, last_w;
    logic [FRAC_W:0] step_w;

    fir_seq_step #(.FRAC_W(FRAC_W), .MIN_SHIFT(MIN_SHIFT)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .ratio_i (ratio_i),
        .step_o  (step_w)
    );

    fir_seq_addr #(.RAM_AW(RAM_AW), .ROM_IW(ROM_IW), .FRAC_W(FRAC_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .reload_i (reload_w),
        .adv_i    (adv_w),
        .ptr_i    (ram_ptr_i),
        .phase_i  (rom_phase_i),
        .step_i   (step_w),
        .ram_o    (ram_addr_o),
        .rom_o    (rom_addr_o),
        .last_o   (last_w)
    );

    fir_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .last_i      (last_w),
        .load_o      (load_w),
        .reload_o    (reload_w),
        .adv_o       (adv_w),
        .ch_o        (ch_o),
        .mac_clr_o   (mac_clr_o),
        .mac_en_o    (mac_en_o),
        .res_valid_o (res_valid_o),
        .res_ch_o    (res_ch_o),
        .overrun_o   (overrun_o)
    );

    // R2: buffer address walks back by one between taps of a channel.
    a_r2_ram_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en_o && !mac_clr_o) |-> (ram_addr_o == RAM_AW'($past(ram_addr_o) - 1'b1)));

    // R3: coefficient address advances by the held step between taps.
    a_r3_rom_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en_o && !mac_clr_o) |->
        (rom_addr_o == ROM_W'($past(rom_addr_o) + {{ROM_IW{1'b0}}, step_w})));

    // R6: a result strobe only follows a cycle in which a tap was issued.
    a_r6_valid_after_tap: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(mac_en_o));

    // R5: the right channel starts straight after the left one ends.
    a_r5_right_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ch_o) |-> (mac_en_o && ch_o && mac_clr_o));
endmodule

// File: tb/fir_seq_bench.sv
`timescale 1ns/1ps
module fir_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  ram_ptr_i = '0;
    logic [19:0] rom_phase_i = '0;
    logic [20:0] ratio_i = '0;
    logic [6:0]  ram_addr_o;
    logic [25:0] rom_addr_o;
    logic        ch_o, mac_clr_o, mac_en_o, res_valid_o, res_ch_o, overrun_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fir_seq u_fir_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ram_ptr_i(ram_ptr_i),
        .rom_phase_i(rom_phase_i), .ratio_i(ratio_i), .ram_addr_o(ram_addr_o),
        .rom_addr_o(rom_addr_o), .ch_o(ch_o), .mac_clr_o(mac_clr_o),
        .mac_en_o(mac_en_o), .res_valid_o(res_valid_o), .res_ch_o(res_ch_o),
        .overrun_o(overrun_o)
    );

    typedef struct packed {
        logic [6:0]  ptr;
        logic [19:0] ph;
        logic [20:0] ratio;
        logic        ovr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{7'd10,  20'h00000, 21'h100000, 1'b0},
        '{7'd3,   20'h54321, 21'h180000, 1'b1},
        '{7'd127, 20'h00000, 21'h080000, 1'b0},
        '{7'd64,  20'h12345, 21'h0C0000, 1'b1},
        '{7'd0,   20'hFFFFF, 21'h000100, 1'b0},
        '{7'd77,  20'h80000, 21'h0FFFFF, 1'b0},
        '{7'd5,   20'h00001, 21'h000000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] clamp_step(input logic [20:0] r);
        if (r >= 21'h100000) return 21'h100000;
        if (r < 21'h010000) return 21'h010000;
        return r;
    endfunction

    function automatic int tap_count(input logic [19:0] ph, input logic [20:0] st);
        logic [31:0] a = {12'd0, ph};
        int n = 0;
        while (a < 32'h0400_0000) begin
            n++;
            a = a + {11'd0, st};
        end
        return n;
    endfunction

    task automatic run_vec(input vec_t v);
        logic [20:0] st = clamp_step(v.ratio);
        int n = tap_count(v.ph, st);
        while (mac_en_o) @(negedge clk);
        ram_ptr_i = v.ptr; rom_phase_i = v.ph; ratio_i = v.ratio; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R8: scramble inputs once the start has been captured
        ram_ptr_i = ~v.ptr; rom_phase_i = v.ph ^ 20'hA5A5A; ratio_i = 21'h1FFFFF ^ v.ratio;
        if (v.ratio == 21'h100000) check("R4 unity ratio gives 64 taps", n, 64);
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < n; k++) begin
                logic [31:0] erom = {12'd0, v.ph} + k * {11'd0, st};
                check(k == 0 ? "R1 first tap buffer address" : "R2 buffer address step R8",
                      ram_addr_o, 7'(v.ptr - k));
                check(k == 0 ? "R1 first tap coefficient address" : "R3 coefficient step R8",
                      rom_addr_o, erom[25:0]);
                check("R5 channel select", ch_o, c);
                check("R10 accumulate enable", mac_en_o, 1);
                check("R10 accumulator clear", mac_clr_o, k == 0);
                check("R6 result strobe", res_valid_o, (c == 1 && k == 0));
                if (c == 1 && k == 0) check("R6 result channel left", res_ch_o, 0);
                check("R7 overrun flag", overrun_o, (v.ovr && c == 0 && k == 4));
                start_i = (v.ovr && c == 0 && k == 3);
                @(negedge clk);
            end
        end
        check("R4 run ends after counted taps", mac_en_o, 0);
        check("R6 right result strobe", res_valid_o, 1);
        check("R6 result channel right", res_ch_o, 1);
        @(negedge clk);
        check("R6 strobe lasts one cycle", res_valid_o, 0);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset enable", mac_en_o, 0);
        check("R9 reset clear", mac_clr_o, 0);
        check("R9 reset strobe", res_valid_o, 0);
        check("R9 reset overrun", overrun_o, 0);
        check("R9 reset addresses", {ram_addr_o, rom_addr_o, ch_o}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: reset in mid-run returns the block to idle
        ram_ptr_i = 7'd20; rom_phase_i = 20'h0; ratio_i = 21'h100000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 mid-run reset idle", mac_en_o, 0);
        check("R9 mid-run reset address", ram_addr_o, 0);
        @(negedge clk);
        check("R9 stays idle after reset", mac_en_o, 0);

        run_vec(VECS[0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule